// File: doc/BRIEF.md
# Multi-Width SPI Transmit Engine

This block is the transmit datapath of an SPI master that can drive one, two or four data lines. A byte-wide FIFO receives data from firmware writes or from a DMA request/acknowledge handshake. A serializer shifts each byte out most significant bits first, on lane 0 alone or across a 2-bit or 4-bit bus. One registered `sck_pulse` marks each shift step, and the clock generator outside the block turns that into a serial clock edge. A per-lane output enable lets each line float when the block is not sending.

Software sets the lane width, the transmit source (FIFO data, constant zeros, constant ones, or off) and the DMA access size. It then pulses `start` with a byte count. The transfer ends after exactly that many bytes. If a FIFO-sourced transfer runs dry, the engine stalls and does not repeat stale data. A clear strobe empties the FIFO and resets all counters. The configuration inputs are assumed stable while `busy` is high.

Top module: `spi_tx_lanes`

## Requirements
- R1: `cfg_lanes` selects the lane width: 0 and 3 give one lane (`io_out[0]`), 1 gives two lanes (`io_out[1:0]`), 2 gives four lanes (`io_out[3:0]`). Bits leave most significant first, and the higher-numbered lane carries the more significant bit. A byte takes 8, 4 or 2 pulses of `sck_pulse`.
- R2: With `cfg_src` = 1, bytes are sent in the order they entered the FIFO.
- R3: With `cfg_src` = 2 every lane sends 0, and with `cfg_src` = 3 every lane sends 1. In both of these modes the FIFO is never read, so its contents stay in place for a later transfer.
- R4: With `cfg_src` = 0, `io_oe` is 0 on every lane and `start` is ignored. With any other source, `io_oe` is 1 exactly on the lanes of the selected width. `io_oe` follows the configuration one cycle later.
- R5: Dual or quad width combined with a nonzero `cfg_src` and `cfg_rx_on` = 1 is illegal. In that case `cfg_err` reads 1, `io_oe` is 0 and `start` is ignored. Single width with receive on is legal.
- R6: `cfg_dma` sets the DMA access size: 0 means off, 1 means 1 byte, 2 means 2 bytes, 3 means 4 bytes. A request rises only for a FIFO-sourced transfer, and only when the FIFO has at least that many free entries. Each request stays high for exactly that many `dma_ack` beats. An acknowledge while the request is low is ignored.
- R7: No new request is raised once the bytes still to be fetched are fewer than the access size. Firmware writes supply the remainder.
- R8: A `dma_done` pulse drops `dma_req` on the next cycle. No further request is raised for the rest of that transfer.
- R9: A `buf_clr` pulse empties the FIFO, aborts any transfer and clears all counters. `busy` falls on the next cycle.
- R10: If the FIFO is empty when a FIFO-sourced transfer needs a byte, no `sck_pulse` occurs until data arrives.
- R11: A transfer sends exactly `xfer_len` bytes and then drops `busy`. A length of 0 starts nothing.
- R12: After reset, `busy`, `sck_pulse`, `dma_req`, `cfg_err` and `io_oe` are all 0.
- R13: A firmware write to a full FIFO is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_lanes | input | 2 | Lane width select |
| cfg_src | input | 2 | Transmit source select |
| cfg_dma | input | 2 | DMA access size code |
| cfg_rx_on | input | 1 | Receive direction is enabled elsewhere |
| buf_clr | input | 1 | Clear strobe for FIFO and counters |
| start | input | 1 | Begin a transfer |
| xfer_len | input | LEN_W | Transfer length in bytes |
| fw_wr | input | 1 | Firmware FIFO write |
| fw_data | input | 8 | Firmware write data |
| dma_req | output | 1 | DMA request |
| dma_ack | input | 1 | DMA data beat valid |
| dma_data | input | 8 | DMA data byte |
| dma_done | input | 1 | DMA termination |
| busy | output | 1 | Transfer in progress |
| sck_pulse | output | 1 | One shift step happened |
| io_out | output | 4 | Lane data |
| io_oe | output | 4 | Per-lane output enable |
| cfg_err | output | 1 | Illegal width/direction combination |

## Verification
The assertions check on every cycle that a DMA request rises only with DMA enabled and enough FIFO room, and that a termination pulse drops the request. They also check that constant-source modes never pop the FIFO, that an illegal configuration keeps every lane released, and that lanes above lane 0 are enabled only in dual or quad width. The bench scenarios cover what a single cycle cannot show: lane order and bit order in each width, the exact byte count, the stall on an empty FIFO, the tail left to firmware, the FIFO contents surviving constant modes, and the effect of the clear strobe.

// File: rtl/spi_tx_pkg.sv
package spi_tx_pkg;
  typedef enum logic [1:0] {
    SRC_OFF  = 2'd0,
    SRC_FIFO = 2'd1,
    SRC_ZERO = 2'd2,
    SRC_ONE  = 2'd3
  } tx_src_e;

  typedef enum logic [1:0] {
    LANE_X1   = 2'd0,
    LANE_X2   = 2'd1,
    LANE_X4   = 2'd2,
    LANE_RSVD = 2'd3
  } lane_mode_e;

  // access size in bytes for a DMA code
  function automatic logic [2:0] dma_beats(input logic [1:0] code);
    case (code)
      2'd1:    return 3'd1;
      2'd2:    return 3'd2;
      2'd3:    return 3'd4;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/spi_tx_fifo.sv
module spi_tx_fifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/spi_tx_dma.sv
module spi_tx_dma #(
  parameter int LEN_W = 16,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic [LEN_W-1:0] len,
  input  logic             enable,
  input  logic [2:0]       size,
  input  logic [CNT_W-1:0] free,
  input  logic             ack,
  input  logic             done,
  output logic             req,
  output logic             push
);
  logic [LEN_W-1:0] fetch_left;
  logic [2:0]       beats_left;
  logic             stopped;
  logic             room_ok, len_ok;

  assign push    = req && ack;
  assign room_ok = 32'(free) >= 32'(size);
  assign len_ok  = 32'(fetch_left) >= 32'(size);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      req        <= 1'b0;
      beats_left <= '0;
      stopped    <= 1'b0;
      fetch_left <= '0;
    end else begin
      if (done) begin
        req        <= 1'b0;
        beats_left <= '0;
        stopped    <= 1'b1;
      end else if (req) begin
        if (ack) begin
          beats_left <= beats_left - 1'b1;
          if (beats_left == 3'd1) req <= 1'b0;
        end
      end else if (enable && !stopped && size != 3'd0 && len_ok && room_ok) begin
        req        <= 1'b1;
        beats_left <= size;
      end
      if (push) fetch_left <= fetch_left - 1'b1;
      if (load) begin
        fetch_left <= len;
        stopped    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_tx_serial.sv
module spi_tx_serial
  import spi_tx_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             start_ok,
  input  logic [LEN_W-1:0] len,
  input  tx_src_e          src,
  input  lane_mode_e       lanes,
  input  logic             fifo_empty,
  input  logic [7:0]       fifo_dout,
  output logic             pop,
  output logic             active,
  output logic             sck_pulse,
  output logic [3:0]       io_out
);
  logic [LEN_W-1:0] bytes_left;
  logic [3:0]       steps;
  logic [3:0]       steps_per;
  logic [7:0]       sh, sh_next, load_byte;
  logic [3:0]       lane_bits;
  logic             need_byte, from_fifo, load;

  assign need_byte = active && steps == 4'd0 && bytes_left != '0;
  assign from_fifo = (src == SRC_FIFO);
  assign pop       = need_byte && from_fifo && !fifo_empty;
  assign load      = need_byte && (!from_fifo || !fifo_empty);

  always_comb begin
    if (from_fifo)            load_byte = fifo_dout;
    else if (src == SRC_ONE)  load_byte = 8'hFF;
    else                      load_byte = 8'h00;
  end

  always_comb begin
    case (lanes)
      LANE_X2: begin
        steps_per = 4'd4;
        lane_bits = {2'b00, sh[7:6]};
        sh_next   = {sh[5:0], 2'b00};
      end
      LANE_X4: begin
        steps_per = 4'd2;
        lane_bits = sh[7:4];
        sh_next   = {sh[3:0], 4'b0000};
      end
      default: begin
        steps_per = 4'd8;
        lane_bits = {3'b000, sh[7]};
        sh_next   = {sh[6:0], 1'b0};
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      active     <= 1'b0;
      bytes_left <= '0;
      steps      <= '0;
      sh         <= '0;
      sck_pulse  <= 1'b0;
      io_out     <= '0;
    end else begin
      sck_pulse <= 1'b0;
      if (start_ok) begin
        active     <= (len != '0);
        bytes_left <= len;
      end else if (active && steps == 4'd0 && bytes_left == '0) begin
        active <= 1'b0;
      end
      if (load) begin
        sh    <= load_byte;
        steps <= steps_per;
      end else if (steps != 4'd0) begin
        sck_pulse <= 1'b1;
        io_out    <= lane_bits;
        sh        <= sh_next;
        steps     <= steps - 1'b1;
        if (steps == 4'd1) bytes_left <= bytes_left - 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_tx_lanes.sv
module spi_tx_lanes
  import spi_tx_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int LEN_W      = 16,
  localparam int CNT_W     = $clog2(FIFO_DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cfg_lanes,
  input  logic [1:0]       cfg_src,
  input  logic [1:0]       cfg_dma,
  input  logic             cfg_rx_on,
  input  logic             buf_clr,
  input  logic             start,
  input  logic [LEN_W-1:0] xfer_len,
  input  logic             fw_wr,
  input  logic [7:0]       fw_data,
  output logic             dma_req,
  input  logic             dma_ack,
  input  logic [7:0]       dma_data,
  input  logic             dma_done,
  output logic             busy,
  output logic             sck_pulse,
  output logic [3:0]       io_out,
  output logic [3:0]       io_oe,
  output logic             cfg_err
);
  lane_mode_e lanes;
  tx_src_e    src;
  logic       wide, bad_cfg, start_ok;
  logic [3:0] oe_next;
  logic [2:0] dma_size;

  logic             dma_push, fifo_push, fifo_pop, fifo_full, fifo_empty;
  logic [7:0]       fifo_din, fifo_dout;
  logic [CNT_W-1:0] fifo_count, fifo_free;

  assign lanes    = lane_mode_e'(cfg_lanes);
  assign src      = tx_src_e'(cfg_src);
  assign wide     = (lanes == LANE_X2) || (lanes == LANE_X4);
  assign bad_cfg  = wide && src != SRC_OFF && cfg_rx_on;
  assign start_ok = start && !busy && !bad_cfg && src != SRC_OFF;
  assign dma_size = dma_beats(cfg_dma);

  always_comb begin
    if (bad_cfg || src == SRC_OFF) oe_next = 4'b0000;
    else if (lanes == LANE_X2)     oe_next = 4'b0011;
    else if (lanes == LANE_X4)     oe_next = 4'b1111;
    else                           oe_next = 4'b0001;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_oe   <= '0;
      cfg_err <= 1'b0;
    end else begin
      io_oe   <= oe_next;
      cfg_err <= bad_cfg;
    end
  end

  // a DMA beat takes the write port; a colliding firmware write is dropped
  assign fifo_push = dma_push || fw_wr;
  assign fifo_din  = dma_push ? dma_data : fw_data;
  assign fifo_free = CNT_W'(FIFO_DEPTH) - fifo_count;

  spi_tx_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) u_fifo (
    .clk(clk), .rst(rst), .clr(buf_clr),
    .push(fifo_push), .din(fifo_din), .pop(fifo_pop), .dout(fifo_dout),
    .count(fifo_count), .full(fifo_full), .empty(fifo_empty)
  );

  spi_tx_dma #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_dma (
    .clk(clk), .rst(rst), .clr(buf_clr),
    .load(start_ok), .len(xfer_len),
    .enable(busy && src == SRC_FIFO && !fifo_full),
    .size(dma_size), .free(fifo_free),
    .ack(dma_ack), .done(dma_done), .req(dma_req), .push(dma_push)
  );

  spi_tx_serial #(.LEN_W(LEN_W)) u_ser (
    .clk(clk), .rst(rst), .clr(buf_clr),
    .start_ok(start_ok), .len(xfer_len), .src(src), .lanes(lanes),
    .fifo_empty(fifo_empty), .fifo_dout(fifo_dout), .pop(fifo_pop),
    .active(busy), .sck_pulse(sck_pulse), .io_out(io_out)
  );
endmodule

// File: rtl/spi_tx_lanes_chk.sv
module spi_tx_lanes_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       cfg_lanes,
  input logic [1:0]       cfg_src,
  input logic [1:0]       cfg_dma,
  input logic             dma_req,
  input logic             dma_done,
  input logic [3:0]       io_oe,
  input logic             cfg_err,
  input logic             fifo_pop,
  input logic [CNT_W-1:0] fifo_free,
  input logic [2:0]       dma_size
);
  // R6
  dma_room_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dma_req) |-> 32'($past(fifo_free)) >= 32'($past(dma_size)));

  // R6
  dma_off_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dma_req) |-> $past(cfg_dma) != 2'd0);

  // R8
  dma_stop_chk: assert property (@(posedge clk) disable iff (rst)
    $past(dma_done) |-> !dma_req);

  // R3
  const_no_pop_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> cfg_src == 2'd1);

  // R5
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> io_oe == 4'b0000);

  // R1
  narrow_oe_chk: assert property (@(posedge clk) disable iff (rst)
    (io_oe[3:1] != 3'b000) |-> ($past(cfg_lanes) == 2'd1 || $past(cfg_lanes) == 2'd2));
endmodule

bind spi_tx_lanes spi_tx_lanes_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_lanes(cfg_lanes), .cfg_src(cfg_src),
  .cfg_dma(cfg_dma), .dma_req(dma_req), .dma_done(dma_done),
  .io_oe(io_oe), .cfg_err(cfg_err), .fifo_pop(fifo_pop),
  .fifo_free(fifo_free), .dma_size(dma_size)
);

// File: tb/spi_tx_lanes_bench.sv
`timescale 1ns/1ps
module spi_tx_lanes_bench;
  localparam int DEPTH = 8;
  localparam int LW    = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic [1:0] cfg_lanes = '0, cfg_src = '0, cfg_dma = '0;
  logic cfg_rx_on = 1'b0, buf_clr = 1'b0, start = 1'b0;
  logic [LW-1:0] xfer_len = '0;
  logic fw_wr = 1'b0;
  logic [7:0] fw_data = '0;
  logic dma_req, dma_ack = 1'b0, dma_done = 1'b0;
  logic [7:0] dma_data = '0;
  logic busy, sck_pulse, cfg_err;
  logic [3:0] io_out, io_oe;

  spi_tx_lanes #(.FIFO_DEPTH(DEPTH), .LEN_W(LW)) u_spi_tx_lanes (
    .clk(clk), .rst(rst), .cfg_lanes(cfg_lanes), .cfg_src(cfg_src),
    .cfg_dma(cfg_dma), .cfg_rx_on(cfg_rx_on), .buf_clr(buf_clr),
    .start(start), .xfer_len(xfer_len), .fw_wr(fw_wr), .fw_data(fw_data),
    .dma_req(dma_req), .dma_ack(dma_ack), .dma_data(dma_data),
    .dma_done(dma_done), .busy(busy), .sck_pulse(sck_pulse),
    .io_out(io_out), .io_oe(io_oe), .cfg_err(cfg_err)
  );

  int checks = 0, fails = 0;
  logic [3:0] cap [0:255];
  int ncap = 0;
  logic [7:0] exp_b [0:31];

  // DMA responder
  bit dma_auto = 0;
  int dma_acks = 0, dma_rises = 0, burst_cnt = 0, bad_bursts = 0, want_burst = 0;
  logic prev_req = 1'b0;

  always @(negedge clk) begin
    if (sck_pulse && ncap < 256) begin
      cap[ncap] = io_out;
      ncap++;
    end
  end

  always @(negedge clk) begin
    if (dma_auto && dma_req) begin
      dma_ack  = 1'b1;
      dma_data = 8'(128 + dma_acks);
      dma_acks++;
      burst_cnt++;
    end else begin
      dma_ack = 1'b0;
    end
    if (dma_req && !prev_req) dma_rises++;
    if (!dma_req && prev_req) begin
      if (burst_cnt != want_burst) bad_bursts++;
      burst_cnt = 0;
    end
    prev_req = dma_req;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [3:0] exp_lane(input logic [7:0] b, input int w, input int s);
    if (w == 1)      return {3'b000, b[7-s]};
    else if (w == 2) return 4'((b >> (6 - 2*s)) & 8'h03);
    else             return 4'((b >> (4 - 4*s)) & 8'h0F);
  endfunction

  task automatic check_stream(input int w, input int n, input string req);
    int spb = 8 / w;
    int bad = 0;
    logic [3:0] mask = (w == 1) ? 4'b0001 : (w == 2) ? 4'b0011 : 4'b1111;
    chk(ncap == n*spb, {req, " pulse count"}, ncap, n*spb);
    for (int i = 0; i < n; i++)
      for (int s = 0; s < spb; s++)
        if (i*spb + s < ncap && (cap[i*spb+s] & mask) != exp_lane(exp_b[i], w, s)) bad++;
    chk(bad == 0, {req, " lane data mismatches"}, bad, 0);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] l, input logic [1:0] s, input logic [1:0] d, input logic r);
    @(negedge clk);
    cfg_lanes = l; cfg_src = s; cfg_dma = d; cfg_rx_on = r;
    tick(2);
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); fw_wr = 1'b1; fw_data = b;
    @(negedge clk); fw_wr = 1'b0;
  endtask

  task automatic go(input int n);
    @(negedge clk); start = 1'b1; xfer_len = LW'(n);
    @(negedge clk); start = 1'b0;
  endtask

  task automatic clear_buf();
    @(negedge clk); buf_clr = 1'b1;
    @(negedge clk); buf_clr = 1'b0;
  endtask

  task automatic wait_idle(input int lim);
    int k = 0;
    while (busy && k < lim) begin
      @(negedge clk);
      k++;
    end
    chk(!busy, "R11 transfer ends", busy, 0);
  endtask

  task automatic t_reset();
    chk(busy == 0 && sck_pulse == 0, "R12 busy/pulse after reset", {busy, sck_pulse}, 0);
    chk(dma_req == 0 && cfg_err == 0, "R12 req/err after reset", {dma_req, cfg_err}, 0);
    chk(io_oe == 4'b0, "R12 oe after reset", io_oe, 0);
  endtask

  task automatic t_widths();
    logic [1:0] modes [4] = '{2'd0, 2'd3, 2'd1, 2'd2};
    dma_rises = 0;
    for (int m = 0; m < 4; m++) begin
      int w = (modes[m] == 2'd1) ? 2 : (modes[m] == 2'd2) ? 4 : 1;
      set_cfg(modes[m], 2'd1, 2'd0, 1'b0);
      push(8'hA5); push(8'h3C);
      exp_b[0] = 8'hA5; exp_b[1] = 8'h3C;
      ncap = 0;
      go(2);
      wait_idle(200);
      check_stream(w, 2, "R1 R2 width/order");
    end
    chk(dma_rises == 0, "R6 no request with DMA off", dma_rises, 0);
    ncap = 0;
    go(0);
    tick(10);
    chk(busy == 0 && ncap == 0, "R11 zero length", ncap, 0);
  endtask

  task automatic t_const();
    set_cfg(2'd0, 2'd1, 2'd0, 1'b0);
    push(8'h5A);
    set_cfg(2'd0, 2'd2, 2'd0, 1'b0);
    ncap = 0; go(2); wait_idle(200);
    exp_b[0] = 8'h00; exp_b[1] = 8'h00;
    check_stream(1, 2, "R3 constant zeros");
    set_cfg(2'd2, 2'd3, 2'd0, 1'b0);
    ncap = 0; go(3); wait_idle(200);
    exp_b[0] = 8'hFF; exp_b[1] = 8'hFF; exp_b[2] = 8'hFF;
    check_stream(4, 3, "R3 constant ones");
    set_cfg(2'd0, 2'd1, 2'd0, 1'b0);
    ncap = 0; go(1); wait_idle(200);
    exp_b[0] = 8'h5A;
    check_stream(1, 1, "R3 FIFO kept through constant modes");
  endtask

  task automatic t_oe();
    set_cfg(2'd0, 2'd1, 2'd0, 1'b0);
    chk(io_oe == 4'b0001, "R4 single oe", io_oe, 4'b0001);
    set_cfg(2'd1, 2'd1, 2'd0, 1'b0);
    chk(io_oe == 4'b0011, "R4 dual oe", io_oe, 4'b0011);
    set_cfg(2'd2, 2'd1, 2'd0, 1'b0);
    chk(io_oe == 4'b1111, "R4 quad oe", io_oe, 4'b1111);
    set_cfg(2'd3, 2'd1, 2'd0, 1'b0);
    chk(io_oe == 4'b0001, "R1 reserved width acts single", io_oe, 4'b0001);
    set_cfg(2'd2, 2'd0, 2'd0, 1'b0);
    chk(io_oe == 4'b0000, "R4 off releases quad", io_oe, 0);
    set_cfg(2'd0, 2'd0, 2'd0, 1'b0);
    chk(io_oe == 4'b0000, "R4 off releases single", io_oe, 0);
    push(8'h11);
    ncap = 0; go(1); tick(20);
    chk(busy == 0 && ncap == 0, "R4 start ignored when off", ncap, 0);
    clear_buf();
  endtask

  task automatic t_illegal();
    set_cfg(2'd1, 2'd1, 2'd0, 1'b1);
    chk(cfg_err == 1'b1, "R5 dual with rx flags error", cfg_err, 1);
    chk(io_oe == 4'b0000, "R5 error releases lanes", io_oe, 0);
    push(8'h22);
    ncap = 0; go(1); tick(20);
    chk(busy == 0 && ncap == 0, "R5 start ignored on error", ncap, 0);
    set_cfg(2'd2, 2'd2, 2'd0, 1'b1);
    chk(cfg_err == 1'b1, "R5 quad with rx flags error", cfg_err, 1);
    set_cfg(2'd0, 2'd1, 2'd0, 1'b1);
    chk(cfg_err == 1'b0 && io_oe == 4'b0001, "R5 single with rx legal", {cfg_err, io_oe}, 5'b00001);
    ncap = 0; go(1); wait_idle(200);
    exp_b[0] = 8'h22;
    check_stream(1, 1, "R5 single with rx sends");
    set_cfg(2'd0, 2'd1, 2'd0, 1'b0);
  endtask

  task automatic t_dma_size(input logic [1:0] code, input int size, input int len, input logic [1:0] lanes);
    int w = (lanes == 2'd1) ? 2 : (lanes == 2'd2) ? 4 : 1;
    clear_buf();
    set_cfg(lanes, 2'd1, code, 1'b0);
    dma_acks = 0; dma_rises = 0; bad_bursts = 0; want_burst = size;
    dma_auto = 1;
    ncap = 0;
    go(len);
    wait_idle(3000);
    tick(2);
    dma_auto = 0;
    chk(dma_acks == len, "R6 total beats", dma_acks, len);
    chk(bad_bursts == 0, "R6 beats per request", bad_bursts, 0);
    chk(dma_rises == len / size, "R6 request count", dma_rises, len / size);
    for (int i = 0; i < len; i++) exp_b[i] = 8'(128 + i);
    check_stream(w, len, "R6 DMA data");
  endtask

  task automatic t_dma_tail();
    clear_buf();
    set_cfg(2'd2, 2'd1, 2'd2, 1'b0);
    dma_acks = 0; dma_rises = 0; bad_bursts = 0; want_burst = 2;
    dma_auto = 1;
    ncap = 0;
    go(3);
    tick(40);
    chk(dma_acks == 2 && dma_rises == 1, "R7 no request for short tail", dma_acks, 2);
    chk(busy == 1'b1, "R7 waits for firmware tail", busy, 1);
    push(8'h77);
    wait_idle(200);
    dma_auto = 0;
    exp_b[0] = 8'h80; exp_b[1] = 8'h81; exp_b[2] = 8'h77;
    check_stream(4, 3, "R7 tail data");
  endtask

  task automatic t_dma_done();
    int n, seen = 0, k = 0;
    clear_buf();
    set_cfg(2'd0, 2'd1, 2'd1, 1'b0);
    dma_acks = 0; want_burst = 1;
    dma_auto = 1;
    ncap = 0;
    go(6);
    while (dma_acks < 2 && k < 100) begin
      @(negedge clk);
      k++;
    end
    @(negedge clk); dma_done = 1'b1;
    @(negedge clk); dma_done = 1'b0;
    chk(dma_req == 1'b0, "R8 request drops after done", dma_req, 0);
    n = dma_acks;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (dma_req) seen++;
    end
    chk(seen == 0 && dma_acks == n, "R8 no further request", seen, 0);
    chk(busy == 1'b1, "R8 transfer waits after done", busy, 1);
    for (int i = 0; i < n; i++) exp_b[i] = 8'(128 + i);
    for (int i = n; i < 6; i++) begin
      exp_b[i] = 8'(64 + i);
      push(exp_b[i]);
    end
    wait_idle(400);
    dma_auto = 0;
    check_stream(1, 6, "R8 data after done");
  endtask

  task automatic t_underrun();
    clear_buf();
    set_cfg(2'd0, 2'd1, 2'd0, 1'b0);
    push(8'hC3);
    ncap = 0;
    go(2);
    tick(40);
    chk(ncap == 8 && busy == 1'b1, "R10 pause on empty FIFO", ncap, 8);
    push(8'h96);
    wait_idle(200);
    exp_b[0] = 8'hC3; exp_b[1] = 8'h96;
    check_stream(1, 2, "R10 resume after refill");
  endtask

  task automatic t_clear();
    set_cfg(2'd0, 2'd1, 2'd0, 1'b0);
    push(8'h01); push(8'h02); push(8'h03);
    clear_buf();
    push(8'hE7);
    ncap = 0; go(1); wait_idle(200);
    exp_b[0] = 8'hE7;
    check_stream(1, 1, "R9 clear empties FIFO");
    push(8'h55);
    go(3);
    tick(30);
    chk(busy == 1'b1, "R9 stalled before clear", busy, 1);
    clear_buf();
    chk(busy == 1'b0, "R9 clear aborts transfer", busy, 0);
    push(8'h99);
    ncap = 0; go(1); wait_idle(200);
    exp_b[0] = 8'h99;
    check_stream(1, 1, "R9 fresh transfer after abort");
  endtask

  task automatic t_full();
    clear_buf();
    set_cfg(2'd2, 2'd1, 2'd0, 1'b0);
    for (int i = 0; i < DEPTH + 2; i++) push(8'(16 + i));
    for (int i = 0; i < DEPTH; i++) exp_b[i] = 8'(16 + i);
    ncap = 0;
    go(DEPTH + 2);
    tick(60);
    chk(busy == 1'b1, "R13 extra writes dropped, transfer stalls", busy, 1);
    check_stream(4, DEPTH, "R13 only first entries kept");
    clear_buf();
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    tick(4);
    rst = 1'b0;
    tick(1);
    t_reset();
    t_widths();
    t_const();
    t_oe();
    t_illegal();
    t_dma_size(2'd1, 1, 8, 2'd0);
    t_dma_size(2'd2, 2, 8, 2'd1);
    t_dma_size(2'd3, 4, 16, 2'd2);
    t_dma_tail();
    t_dma_done();
    t_underrun();
    t_clear();
    t_full();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule